// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel that walks a chain of buffer descriptors held in system memory and turns each referenced buffer into an outgoing byte stream. Software builds descriptors, marks them as owned by hardware, and points the channel at the first one. The channel fetches the four descriptor words and streams the buffer bytes. It then reads the link word again and writes the status word back with ownership returned to software. After that it either follows the link or stops.

Re-reading the link just before write-back lets software append a descriptor while the channel is still running. If the chain had already ended, the written-back status carries an end-of-queue flag. Software then knows it must restart the channel by writing the head pointer again. A completion-pointer register lets the host acknowledge processed descriptors, and an interrupt line stays high until it does. The host can park the channel at a descriptor boundary with an idle command, gate it with an enable bit, or abort it with a self-clearing soft reset.

A descriptor at address D is four little-endian 32-bit words: link at D, buffer address at D+4, buffer length at D+8 and status/flags at D+12. In the status word, bit 31 marks start of packet, bit 30 end of packet, bit 29 hardware ownership and bit 28 end of queue. Bits 10:0 hold the length. The engine is one state machine with these states and transitions. WAIT_IDLE goes to FETCH_DESC when a head pointer is pending, the channel is enabled and no idle command is set. FETCH_DESC goes to CHECK_OWN after the fourth word is granted. CHECK_OWN goes to WAIT_IDLE when the ownership bit is clear. It goes to RELINK for a zero length, and to READ_WORD otherwise. READ_WORD goes to STREAM on grant. STREAM goes to RELINK after the last byte is accepted, and to READ_WORD after the last byte of a word. RELINK goes to WRITE_BACK on grant. WRITE_BACK goes to FETCH_DESC to follow a nonzero link, or to WAIT_IDLE at the end of the chain or when stopped. A soft reset forces WAIT_IDLE from any state.

Top module: `txq_desc_dma`

## Requirements
- R1: After reset the status register (register index 3) reads bit 31 = 1. The control register (index 0) reads 0, irq is 0, and neither tx_valid nor mem_req is asserted.
- R2: Writing a nonzero address to the head register (index 4) while the channel is idle and enabled starts a fetch of the words at head, head+4, head+8 and head+12. A memory request keeps its address and direction stable until it is granted.
- R3: The channel sends exactly as many bytes as bits 10:0 of the buffer-length word, in rising address order starting at the buffer address, which need not be word aligned. The byte at address a comes from bits 8*(a mod 4)+7 : 8*(a mod 4) of its memory word. tx_last is high only on the final byte, and only if status bit 30 is set. Data and last hold while tx_valid is high and tx_ready is low.
- R4: After streaming, the channel writes the status word at D+12 with bit 29 cleared and all other bits kept. Bit 28 is set exactly when the link word is 0.
- R5: The link word is read again after the buffer has been sent. A nonzero value written into the link during transmission is followed, and no end-of-queue is set on that descriptor.
- R6: A descriptor whose status bit 29 is clear causes no byte output and no write-back, and the channel returns to idle.
- R7: irq is high while the completion register (index 5) differs from the address of the last written-back descriptor. It is low while no descriptor has been written back since reset or soft reset.
- R8: Setting bit 3 of the command register (index 2) makes the channel stop after the write-back of the current descriptor, with no end-of-queue set. Clearing it resumes at the following descriptor.
- R9: While control bit 0 (register index 0) is 0, a head write is held and nothing is fetched. Setting the bit starts the held chain.
- R10: Writing bit 0 of the soft-reset register (index 1) makes it read 1 for one cycle and 0 afterwards. The write aborts any transfer, returns the channel to idle, drops irq and discards a held head pointer.
- R11: A descriptor with length 0 sends no bytes but is still written back as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Unacknowledged completion pending |

## Verification
The bench builds the channel with its defaults: 32-bit addresses, an 11-bit length field and a 3-bit register index. That covers the whole register map and lengths far beyond the 60-byte buffers used. Descriptors and buffers sit in a 4 KB model memory that grants at random. The buffers start at random byte offsets, so streams cross word boundaries at every lane. Random sink back-pressure reaches the hold behaviour of the byte stream. Directed cases cover owner-clear, zero length, a link appended mid-packet, the idle command, a disabled start and a soft reset while a byte is stalled.

// File: rtl/txq_pkg.sv
package txq_pkg;
    // status/flag word bit positions (decoded by software)
    localparam int FLG_SOP = 31;
    localparam int FLG_EOP = 30;
    localparam int FLG_OWN = 29;
    localparam int FLG_EOQ = 28;

    // register word indices
    localparam int RIX_CTRL = 0;
    localparam int RIX_SRST = 1;
    localparam int RIX_CMD  = 2;
    localparam int RIX_STAT = 3;
    localparam int RIX_HEAD = 4;
    localparam int RIX_CPL  = 5;

    localparam int CMD_IDLE_BIT  = 3;
    localparam int STAT_IDLE_BIT = 31;

    typedef enum logic [2:0] {
        WAIT_IDLE,
        FETCH_DESC,
        CHECK_OWN,
        READ_WORD,
        STREAM,
        RELINK,
        WRITE_BACK
    } eng_state_t;
endpackage

// File: rtl/txq_csr.sv
module txq_csr
    import txq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_idle,
    input  logic [AW-1:0]     eng_head,
    output logic              chan_en,
    output logic              idle_req,
    output logic              srst,
    output logic              head_wr,
    output logic [AW-1:0]     head_val,
    output logic [AW-1:0]     cpl_ptr
);
    logic wr_ctrl, wr_srst, wr_cmd, wr_cpl;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == REG_AW'(RIX_CTRL));
        wr_srst = reg_wr && (reg_addr == REG_AW'(RIX_SRST));
        wr_cmd  = reg_wr && (reg_addr == REG_AW'(RIX_CMD));
        wr_cpl  = reg_wr && (reg_addr == REG_AW'(RIX_CPL));
        head_wr = reg_wr && (reg_addr == REG_AW'(RIX_HEAD));
        head_val = reg_wdata[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_en  <= 1'b0;
            idle_req <= 1'b0;
            srst     <= 1'b0;
            cpl_ptr  <= '0;
        end else begin
            srst <= wr_srst && reg_wdata[0];
            if (wr_ctrl) chan_en  <= reg_wdata[0];
            if (wr_cmd)  idle_req <= reg_wdata[CMD_IDLE_BIT];
            if (srst)        cpl_ptr <= '0;
            else if (wr_cpl) cpl_ptr <= reg_wdata[AW-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(RIX_CTRL)) reg_rdata[0] = chan_en;
        if (reg_addr == REG_AW'(RIX_SRST)) reg_rdata[0] = srst;
        if (reg_addr == REG_AW'(RIX_CMD))  reg_rdata[CMD_IDLE_BIT] = idle_req;
        if (reg_addr == REG_AW'(RIX_STAT)) reg_rdata[STAT_IDLE_BIT] = eng_idle;
        if (reg_addr == REG_AW'(RIX_HEAD)) reg_rdata[AW-1:0] = eng_head;
        if (reg_addr == REG_AW'(RIX_CPL))  reg_rdata[AW-1:0] = cpl_ptr;
    end

    // R10: the reset bit clears itself one cycle later
    a_r10_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && !wr_srst) |=> !srst);
endmodule

// File: rtl/txq_cpl.sv
module txq_cpl #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          wb_done,
    input  logic [AW-1:0] wb_addr,
    input  logic [AW-1:0] cpl_ptr,
    output logic          irq
);
    logic [AW-1:0] last_wb;
    logic          wb_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wb <= '0;
            wb_seen <= 1'b0;
        end else if (srst) begin
            last_wb <= '0;
            wb_seen <= 1'b0;
        end else if (wb_done) begin
            last_wb <= wb_addr;
            wb_seen <= 1'b1;
        end
    end

    assign irq = wb_seen && (last_wb != cpl_ptr);

    // R7: a soft reset leaves nothing to acknowledge
    a_r7_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && !wb_done) |=> !irq);
endmodule

// File: rtl/txq_engine.sv
module txq_engine
    import txq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          chan_en,
    input  logic          idle_req,
    input  logic          head_wr,
    input  logic [AW-1:0] head_val,
    output logic [AW-1:0] head_ptr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          eng_idle,
    output logic          wb_done,
    output logic [AW-1:0] wb_addr
);
    localparam logic [AW-1:0] FLAG_OFS = AW'(12);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    eng_state_t     state, nxt;
    logic [AW-1:0]  cur, d_next, d_buf, ptr;
    logic [LEN_W-1:0] d_len, rem;
    logic [31:0]    d_flags, word;
    logic [1:0]     idx;
    logic           pending, stop_req, link_end;

    assign stop_req = idle_req || !chan_en;
    assign link_end = (d_next == '0);
    assign head_ptr = cur;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            WAIT_IDLE:  if (pending && !stop_req) nxt = FETCH_DESC;
            FETCH_DESC: if (mem_gnt && idx == 2'd3) nxt = CHECK_OWN;
            CHECK_OWN: begin
                if (!d_flags[FLG_OWN])   nxt = WAIT_IDLE;
                else if (d_len == '0)    nxt = RELINK;
                else                     nxt = READ_WORD;
            end
            READ_WORD:  if (mem_gnt) nxt = STREAM;
            STREAM: begin
                if (tx_ready) begin
                    if (rem == LEN_ONE)        nxt = RELINK;
                    else if (ptr[1:0] == 2'b11) nxt = READ_WORD;
                end
            end
            RELINK:     if (mem_gnt) nxt = WRITE_BACK;
            WRITE_BACK: begin
                if (mem_gnt) nxt = (link_end || stop_req) ? WAIT_IDLE : FETCH_DESC;
            end
            default:    nxt = WAIT_IDLE;
        endcase
    end

    // state register and descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WAIT_IDLE; cur <= '0; d_next <= '0; d_buf <= '0;
            d_len <= '0; d_flags <= '0; ptr <= '0; rem <= '0; word <= '0;
            idx <= '0; pending <= 1'b0;
        end else if (srst) begin
            state <= WAIT_IDLE; pending <= 1'b0; cur <= '0; idx <= '0;
        end else begin
            state <= nxt;
            case (state)
                WAIT_IDLE: begin
                    if (nxt == FETCH_DESC) begin
                        pending <= 1'b0;
                        idx     <= '0;
                    end else if (head_wr) begin
                        cur     <= head_val;
                        pending <= (head_val != '0);
                    end
                end
                FETCH_DESC: if (mem_gnt) begin
                    case (idx)
                        2'd0:    d_next  <= mem_rdata[AW-1:0];
                        2'd1:    d_buf   <= mem_rdata[AW-1:0];
                        2'd2:    d_len   <= mem_rdata[LEN_W-1:0];
                        default: d_flags <= mem_rdata;
                    endcase
                    idx <= idx + 2'd1;
                end
                CHECK_OWN: begin
                    ptr <= d_buf;
                    rem <= d_len;
                end
                READ_WORD: if (mem_gnt) word <= mem_rdata;
                STREAM: if (tx_ready) begin
                    ptr <= ptr + AW'(1);
                    rem <= rem - LEN_ONE;
                end
                RELINK: if (mem_gnt) d_next <= mem_rdata[AW-1:0];
                WRITE_BACK: if (mem_gnt && !link_end) begin
                    cur <= d_next;
                    idx <= '0;
                    if (stop_req) pending <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = word[{ptr[1:0], 3'b000} +: 8];
        tx_last   = (rem == LEN_ONE) && d_flags[FLG_EOP];
        eng_idle  = 1'b0;
        wb_done   = 1'b0;
        wb_addr   = cur;
        unique case (state)
            WAIT_IDLE:  eng_idle = 1'b1;
            FETCH_DESC: begin
                mem_req  = 1'b1;
                mem_addr = cur + {{(AW-4){1'b0}}, idx, 2'b00};
            end
            CHECK_OWN:  ;
            READ_WORD: begin
                mem_req  = 1'b1;
                mem_addr = {ptr[AW-1:2], 2'b00};
            end
            STREAM:     tx_valid = 1'b1;
            RELINK: begin
                mem_req  = 1'b1;
                mem_addr = cur;
            end
            WRITE_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + FLAG_OFS;
                mem_wdata = d_flags;
                mem_wdata[FLG_OWN] = 1'b0;
                mem_wdata[FLG_EOQ] = link_end;
                wb_done   = mem_gnt;
            end
            default:    ;
        endcase
    end

    // R2: an ungranted request holds still
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !srst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R3: a stalled byte stays put
    a_r3_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R4: write-back always returns ownership to software
    a_r4_owner_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[FLG_OWN]);
    // R6: a descriptor not owned by hardware ends the walk
    a_r6_unowned_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CHECK_OWN && !d_flags[FLG_OWN] && !srst) |=> (eng_idle && !mem_req && !tx_valid));
    // R8: an idle channel neither streams nor touches memory
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |-> (!tx_valid && !mem_req));
endmodule

// File: rtl/txq_desc_dma.sv
module txq_desc_dma #(
    parameter int AW     = 32,
    parameter int LEN_W  = 11,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq
);
    logic          chan_en, idle_req, srst, head_wr, eng_idle, wb_done;
    logic [AW-1:0] head_val, cpl_ptr, head_ptr, wb_addr;

    txq_csr #(.AW(AW), .REG_AW(REG_AW)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle),
        .eng_head(head_ptr), .chan_en(chan_en), .idle_req(idle_req),
        .srst(srst), .head_wr(head_wr), .head_val(head_val), .cpl_ptr(cpl_ptr)
    );

    txq_engine #(.AW(AW), .LEN_W(LEN_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .srst(srst), .chan_en(chan_en),
        .idle_req(idle_req), .head_wr(head_wr), .head_val(head_val),
        .head_ptr(head_ptr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .eng_idle(eng_idle),
        .wb_done(wb_done), .wb_addr(wb_addr)
    );

    txq_cpl #(.AW(AW)) u_cpl (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wb_done(wb_done),
        .wb_addr(wb_addr), .cpl_ptr(cpl_ptr), .irq(irq)
    );

    // R1: after reset the channel is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_valid && !mem_req && !irq));
endmodule

// File: tb/txq_desc_dma_bench.sv
`timescale 1ns/1ps
module txq_desc_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    always #2.5 clk = ~clk;

    txq_desc_dma u_txq_desc_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
    );

    localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000;
    localparam logic [31:0] OWN = 32'h2000_0000, EOQ = 32'h1000_0000;

    logic [31:0] mem [0:1023];
    logic [7:0]  cap_d [0:4095];
    logic        cap_l [0:4095];
    int          cap_n = 0;
    int          rdy_mode = 1;   // 0 random, 1 always, 2 never
    int          nchk = 0, nfail = 0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13 + 5) ^ (a >> 8));
    endfunction

    // memory model and byte sink, updated away from the active edge
    always @(negedge clk) begin
        mem_gnt = mem_req && ($urandom_range(3) != 0);
        if (mem_gnt) begin
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[11:2]];
        end
        case (rdy_mode)
            0: tx_ready = ($urandom_range(2) != 0);
            1: tx_ready = 1'b1;
            default: tx_ready = 1'b0;
        endcase
        if (tx_valid && tx_ready && cap_n < 4096) begin
            cap_d[cap_n] = tx_data;
            cap_l[cap_n] = tx_last;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(idx); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int idx, output logic [31:0] d);
        reg_addr = 3'(idx);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            reg_read(3, v);
            if (v[31]) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_desc(input int a, input logic [31:0] nx, input int b, input int len, input logic [31:0] fl);
        mem[a/4]     = nx;
        mem[a/4 + 1] = 32'(b);
        mem[a/4 + 2] = 32'(len);
        mem[a/4 + 3] = fl | 32'(len);
    endtask

    // compare captured bytes [first, first+len) against the buffer pattern
    task automatic chk_bytes(input int first, input int b, input int len, input bit eop, input string tag);
        int bad = 0, lastbad = 0;
        for (int i = 0; i < len; i++) begin
            if (cap_d[first + i] !== pat(b + i)) bad++;
            if (cap_l[first + i] !== (eop && i == len - 1)) lastbad++;
        end
        chk(bad == 0, {tag, " byte order/content"}, 32'(bad), 0);
        chk(lastbad == 0, {tag, " last flag placement"}, 32'(lastbad), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, orig, orig2;
        int seed;
        seed = int'($urandom(32'd20240611));
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(3, v); chk(v[31] == 1'b1, "R1 status idle", v, 32'h8000_0000);
        reg_read(0, v); chk(v == 0, "R1 control zero", v, 0);
        chk(!irq && !tx_valid && !mem_req, "R1 outputs quiet", {irq, tx_valid, mem_req}, 0);

        // R2 R3 R4 R7 single descriptor
        reg_write(0, 1);
        set_desc(32'h100, 0, 32'h400, 5, SOP | EOP | OWN);
        orig = mem[32'h10C/4];
        cap_n = 0; rdy_mode = 1;
        reg_write(4, 32'h100);
        wait_idle();
        chk(cap_n == 5, "R2 R3 byte count", 32'(cap_n), 5);
        chk_bytes(0, 32'h400, 5, 1, "R3 single");
        chk(mem[32'h10C/4] == ((orig & ~OWN) | EOQ), "R4 write-back word", mem[32'h10C/4], (orig & ~OWN) | EOQ);
        chk(irq == 1'b1, "R7 irq raised", 32'(irq), 1);
        reg_write(5, 32'h100);
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq acknowledged", 32'(irq), 0);

        // R3 R4 R5 random chains with back-pressure
        for (int r = 0; r < 6; r++) begin
            int nd, total, lens[3], bufs[3];
            logic [31:0] fl[3];
            nd = $urandom_range(1, 3);
            reg_write(5, 0);
            for (int i = 0; i < nd; i++) begin
                lens[i] = $urandom_range(1, 24);
                bufs[i] = 32'h400 + i * 32'h100 + $urandom_range(0, 3);
                fl[i] = OWN | ((i == 0) ? SOP : 0) | ((i == nd - 1) ? EOP : 0);
                set_desc(32'h100 + 16*i, (i == nd - 1) ? 0 : 32'(32'h110 + 16*i), bufs[i], lens[i], fl[i]);
            end
            cap_n = 0; rdy_mode = 0;
            reg_write(4, 32'h100);
            wait_idle();
            total = 0;
            for (int i = 0; i < nd; i++) total += lens[i];
            chk(cap_n == total, "R5 chain byte count", 32'(cap_n), 32'(total));
            total = 0;
            for (int i = 0; i < nd; i++) begin
                chk_bytes(total, bufs[i], lens[i], i == nd - 1, "R3 chain");
                v = mem[(32'h10C + 16*i)/4];
                chk(v == ((fl[i] | 32'(lens[i])) & ~OWN | ((i == nd - 1) ? EOQ : 0)),
                    "R4 chain write-back", v, (fl[i] | 32'(lens[i])) & ~OWN | ((i == nd - 1) ? EOQ : 0));
                total += lens[i];
            end
            chk(irq == 1'b1, "R7 irq after chain", 32'(irq), 1);
        end
        reg_write(5, 32'h100 + 0);

        // R11 zero length
        rdy_mode = 1;
        set_desc(32'h180, 0, 32'h500, 0, SOP | EOP | OWN);
        cap_n = 0;
        reg_write(4, 32'h180);
        wait_idle();
        chk(cap_n == 0, "R11 no bytes", 32'(cap_n), 0);
        chk(mem[32'h18C/4] == ((SOP | EOP) | EOQ), "R11 write-back", mem[32'h18C/4], SOP | EOP | EOQ);

        // R6 not owned
        set_desc(32'h1C0, 0, 32'h500, 8, SOP | EOP);
        cap_n = 0;
        reg_write(4, 32'h1C0);
        wait_idle();
        chk(cap_n == 0, "R6 no bytes", 32'(cap_n), 0);
        chk(mem[32'h1CC/4] == (SOP | EOP | 8), "R6 no write-back", mem[32'h1CC/4], SOP | EOP | 8);

        // R9 disabled start held
        reg_write(0, 0);
        set_desc(32'h1E0, 0, 32'h600, 7, SOP | EOP | OWN);
        cap_n = 0;
        reg_write(4, 32'h1E0);
        repeat (30) @(negedge clk);
        chk(cap_n == 0, "R9 held while disabled", 32'(cap_n), 0);
        reg_read(3, v); chk(v[31], "R9 idle while disabled", v, 32'h8000_0000);
        reg_write(0, 1);
        wait_idle();
        chk(cap_n == 7, "R9 runs after enable", 32'(cap_n), 7);

        // R8 idle command
        rdy_mode = 0;
        set_desc(32'h200, 32'h210, 32'h700, 40, SOP | OWN);
        set_desc(32'h210, 0, 32'h800, 5, EOP | OWN);
        orig = mem[32'h20C/4]; orig2 = mem[32'h21C/4];
        cap_n = 0;
        reg_write(4, 32'h200);
        reg_write(2, 32'h8);
        wait_idle();
        chk(cap_n == 40, "R8 stops after current", 32'(cap_n), 40);
        chk(mem[32'h20C/4] == (orig & ~OWN), "R8 no end-of-queue", mem[32'h20C/4], orig & ~OWN);
        chk(mem[32'h21C/4] == orig2, "R8 next untouched", mem[32'h21C/4], orig2);
        reg_write(2, 0);
        wait_idle();
        chk(cap_n == 45, "R8 resumes", 32'(cap_n), 45);
        chk_bytes(40, 32'h800, 5, 1, "R8 resumed");
        chk(mem[32'h21C/4] == ((orig2 & ~OWN) | EOQ), "R8 resumed write-back", mem[32'h21C/4], (orig2 & ~OWN) | EOQ);

        // R5 link appended during transmission
        rdy_mode = 1;
        set_desc(32'h240, 0, 32'h900, 30, SOP | OWN);
        set_desc(32'h250, 0, 32'hA00, 6, EOP | OWN);
        orig = mem[32'h24C/4];
        cap_n = 0;
        reg_write(4, 32'h240);
        while (cap_n == 0) @(negedge clk);
        mem[32'h240/4] = 32'h250;
        wait_idle();
        chk(cap_n == 36, "R5 appended followed", 32'(cap_n), 36);
        chk(mem[32'h24C/4] == (orig & ~OWN), "R5 no end-of-queue on extended", mem[32'h24C/4], orig & ~OWN);
        chk_bytes(30, 32'hA00, 6, 1, "R5 appended");

        // R10 soft reset with a stalled byte
        rdy_mode = 2;
        set_desc(32'h280, 0, 32'hB00, 60, SOP | EOP | OWN);
        orig = mem[32'h28C/4];
        cap_n = 0;
        reg_write(4, 32'h280);
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        chk(tx_valid == 1'b1, "R10 stalled before reset", 32'(tx_valid), 1);
        chk(irq == 1'b1, "R7 irq pending before reset", 32'(irq), 1);
        reg_write(1, 1);
        reg_read(1, v); chk(v[0] == 1'b1, "R10 reset bit set", v, 1);
        @(negedge clk);
        reg_read(1, v); chk(v[0] == 1'b0, "R10 reset bit cleared", v, 0);
        chk(!tx_valid && !irq, "R10 stream aborted, irq low", {tx_valid, irq}, 0);
        reg_read(3, v); chk(v[31], "R10 idle after reset", v, 32'h8000_0000);
        chk(mem[32'h28C/4] == orig, "R10 no write-back", mem[32'h28C/4], orig);
        rdy_mode = 1;
        repeat (40) @(negedge clk);
        chk(cap_n == 0, "R10 held head discarded", 32'(cap_n), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule